// File: doc/BRIEF.md
# Trace Packet Emission Sequencer

This block sits behind the control-flow event detector of a processor trace unit. When an interrupt or exception retires, the detector hands over one event descriptor: the event kind, the packet-generation enable before and after the event, the context-match enable after the event, a handful of condition flags and the addresses involved. The sequencer then decides which trace packets the event needs, puts them in the required order, and presents them one per handshake as a packet-type code with a 64-bit payload. Byte encoding, address compression and the stop-region comparators are handled elsewhere.

The packet order depends on the enable transition. Enabling, disabling and fully enabled flows each produce their own sequence. Paging-info, execution-mode and trace-stop packets are optional, and each is governed by its own condition. The block keeps a small record of whether an execution-mode packet has gone out since the last synchronisation point, and which mode value it carried. This record suppresses redundant mode packets on an enabling transition.

The whole sequence is planned when the event is accepted. A state machine then walks a fixed step order and skips every step the plan leaves out. Events are accepted only in the idle state. A one-cycle `seq_done` pulse closes every sequence, including an empty one.

States: `ST_IDLE` (waits for an event, `ev_ready` high), `ST_FUP_CUR` (flow update with the current address), `ST_FUP_NXT_LEAD` (leading flow update with the next sequential address), `ST_PAGING` (paging info), `ST_FUP_NXT` (trailing flow update with the next address), `ST_MODE` (execution mode), `ST_BRANCH` (generation-enable, generation-disable or target packet), `ST_STOP` (trace stop) and `ST_DONE` (done pulse). Transitions: accept (`ST_IDLE` to the first planned step, or to `ST_DONE` when the plan is empty), advance (on `pk_ready` from a step state to the next planned step in the order listed, or to `ST_DONE`), and finish (`ST_DONE` to `ST_IDLE` unconditionally).

Top module: `tpkt_seq`

## Requirements
- R1: After reset the block is idle: `ev_ready`=1, `pk_valid`=0, `seq_done`=0. An event is taken on a clock edge where `ev_valid` and `ev_ready` are both 1. `ev_ready` stays 0 from the cycle after acceptance until the sequence has finished, and `pk_valid` and `ev_ready` are never 1 together.
- R2: A packet transfers on each edge where `pk_valid` and `pk_ready` are both 1. While `pk_valid`=1 and `pk_ready`=0, the type and payload hold steady. `seq_done` is high for exactly one cycle: the cycle after the last packet transfers, or the cycle after acceptance when no packet is due. `ev_ready` returns to 1 in the following cycle.
- R3: `ev_kind` encodes 0 = hardware interrupt, 1 = software interrupt, 2 and 3 = exception. Exceptions emit no packet. A software interrupt with enable-before, enable-after and context-after written as `{before,after,ctx}` equal to 000, 010 or 110 also emits no packet.
- R4: Software interrupt with 100: flow update (type 1) carrying `cur_ip`, then generation-disable (type 5) with payload 0.
- R5: Software interrupt with 011: optional paging info (type 2), optional execution mode (type 3), then generation-enable (type 4) carrying `target_ip`.
- R6: Software interrupt with 101: flow update with `cur_ip`, optional paging info, generation-disable carrying `target_ip`, then optional trace stop (type 7).
- R7: Software interrupt with 111: flow update with `cur_ip`, optional paging info, flow update with `next_ip`, optional execution mode, then target packet (type 6) carrying `target_ip`.
- R8: Hardware interrupt with 111: flow update with `next_ip`, optional paging info, optional execution mode, then target packet with `target_ip`. There is no flow update with `cur_ip`. A hardware interrupt with any other enable combination emits nothing.
- R9: Software interrupt with 001: optional paging info followed by optional trace stop, and nothing else.
- R10: Paging info is emitted, where a sequence allows it, only when `pt_base_upd`=1 and `os_trace_on`=1. Its payload is `pt_base`. `pk_nonroot` is 1 exactly on a paging packet whose event had `dest_nonroot`=1 and `conceal_nonroot`=0, and 0 on every other packet.
- R11: On the enabling transition (R5), the execution-mode packet is emitted if no mode packet has transferred since the last `sync_seen` pulse, or if `mode_val` differs from the value carried by the last mode packet. Its payload is `mode_val` zero-extended. A transferred mode packet updates this record, and `sync_seen` clears the sent indication.
- R12: In the fully enabled flows (R7, R8), the execution-mode packet is emitted exactly when `mode_width_chg`=1, and it still updates the record of R11.
- R13: Trace stop is emitted, where a sequence allows it, only when `stop_region_hit`=1. It carries payload 0 and is always the last packet of its sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Event descriptor offered |
| ev_ready | output | 1 | Block idle, event can be taken |
| ev_kind | input | 2 | 0 hardware interrupt, 1 software interrupt, 2/3 exception |
| en_before | input | 1 | Packet generation enabled before the event |
| en_after | input | 1 | Packet generation enabled after the event |
| ctx_after | input | 1 | Context-match enable after the event |
| pt_base_upd | input | 1 | Page-table base register changed by the event |
| os_trace_on | input | 1 | Supervisor-level tracing enabled |
| dest_nonroot | input | 1 | Destination is non-root (guest) operation |
| conceal_nonroot | input | 1 | Control bit hiding non-root operation |
| mode_width_chg | input | 1 | Event changes code-segment width or long-mode-active |
| stop_region_hit | input | 1 | Branch target lies in a stop region |
| mode_val | input | MODE_W | Execution mode after the event |
| pt_base | input | ADDR_W | New page-table base value |
| cur_ip | input | ADDR_W | Address of the current instruction |
| next_ip | input | ADDR_W | Next sequential address |
| target_ip | input | ADDR_W | Branch target address |
| sync_seen | input | 1 | Synchronisation packet issued; clears the mode-sent record |
| pk_valid | output | 1 | Packet token present |
| pk_ready | input | 1 | Downstream takes the packet |
| pk_type | output | 3 | 1 flow, 2 paging, 3 mode, 4 gen-enable, 5 gen-disable, 6 target, 7 stop |
| pk_nonroot | output | 1 | Non-root flag of a paging packet |
| pk_payload | output | ADDR_W | Address or mode payload |
| seq_done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The bench builds the block with its defaults, ADDR_W = 64 and MODE_W = 3. It sweeps every event kind against all eight enable combinations and all 64 settings of the six condition flags. Because the mode value is only three bits wide and changes slowly across the sweep, both the repeated-mode suppression and the changed-mode emission of R11 occur many times, and periodic sync pulses reopen the first-packet-after-sync case. The full-width payloads are distinct per event, so a swapped current, next or target address shows up at once, and a downstream stall pattern exercises the hold rule of R2 in every state.

// File: rtl/tpkt_pkg.sv
`timescale 1ns/1ps
package tpkt_pkg;

    // packet type codes seen at the output port
    typedef enum logic [2:0] {
        PK_NONE    = 3'd0,
        PK_FLOW    = 3'd1,
        PK_PAGING  = 3'd2,
        PK_MODE    = 3'd3,
        PK_GEN_EN  = 3'd4,
        PK_GEN_DIS = 3'd5,
        PK_TARGET  = 3'd6,
        PK_STOP    = 3'd7
    } pk_kind_t;

    localparam logic [1:0] EVK_HW = 2'd0;
    localparam logic [1:0] EVK_SW = 2'd1;

    localparam int N_STEPS = 7;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FUP_CUR,
        ST_FUP_NXT_LEAD,
        ST_PAGING,
        ST_FUP_NXT,
        ST_MODE,
        ST_BRANCH,
        ST_STOP,
        ST_DONE
    } seq_st_t;

    // packed so that bit 0 is the earliest step in emission order
    typedef struct packed {
        logic stop;
        logic branch;
        logic mode;
        logic fup_nxt;
        logic paging;
        logic fup_nxt_lead;
        logic fup_cur;
    } step_mask_t;

    typedef struct packed {
        step_mask_t steps;
        pk_kind_t   br_kind;
        logic       br_with_tgt;
    } plan_t;

endpackage

// File: rtl/tpkt_plan.sv
`timescale 1ns/1ps
module tpkt_plan
    import tpkt_pkg::*;
(
    input  logic [1:0] ev_kind,
    input  logic       en_before,
    input  logic       en_after,
    input  logic       ctx_after,
    input  logic       pip_ok,
    input  logic       stop_hit,
    input  logic       width_chg,
    input  logic       mode_due,
    output plan_t      plan
);

    logic [2:0] trans;
    assign trans = {en_before, en_after, ctx_after};

    always_comb begin
        plan = '0;
        plan.br_kind = PK_NONE;
        if (ev_kind == EVK_SW) begin
            unique case (trans)
                3'b001: begin
                    plan.steps.paging = pip_ok;
                    plan.steps.stop   = stop_hit;
                end
                3'b011: begin
                    plan.steps.paging = pip_ok;
                    plan.steps.mode   = mode_due;
                    plan.steps.branch = 1'b1;
                    plan.br_kind      = PK_GEN_EN;
                    plan.br_with_tgt  = 1'b1;
                end
                3'b100: begin
                    plan.steps.fup_cur = 1'b1;
                    plan.steps.branch  = 1'b1;
                    plan.br_kind       = PK_GEN_DIS;
                    plan.br_with_tgt   = 1'b0;
                end
                3'b101: begin
                    plan.steps.fup_cur = 1'b1;
                    plan.steps.paging  = pip_ok;
                    plan.steps.branch  = 1'b1;
                    plan.steps.stop    = stop_hit;
                    plan.br_kind       = PK_GEN_DIS;
                    plan.br_with_tgt   = 1'b1;
                end
                3'b111: begin
                    plan.steps.fup_cur = 1'b1;
                    plan.steps.paging  = pip_ok;
                    plan.steps.fup_nxt = 1'b1;
                    plan.steps.mode    = width_chg;
                    plan.steps.branch  = 1'b1;
                    plan.br_kind       = PK_TARGET;
                    plan.br_with_tgt   = 1'b1;
                end
                default: ;
            endcase
        end else if (ev_kind == EVK_HW && trans == 3'b111) begin
            plan.steps.fup_nxt_lead = 1'b1;
            plan.steps.paging       = pip_ok;
            plan.steps.mode         = width_chg;
            plan.steps.branch       = 1'b1;
            plan.br_kind            = PK_TARGET;
            plan.br_with_tgt        = 1'b1;
        end
    end

endmodule

// File: rtl/tpkt_mode_track.sv
`timescale 1ns/1ps
module tpkt_mode_track #(
    parameter int MODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_seen,
    input  logic              fire,
    input  logic [MODE_W-1:0] fire_val,
    input  logic [MODE_W-1:0] cand,
    output logic              due
);

    logic              sent_q;
    logic [MODE_W-1:0] last_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sent_q <= 1'b0;
            last_q <= '0;
        end else if (fire) begin
            sent_q <= 1'b1;
            last_q <= fire_val;
        end else if (sync_seen) begin
            sent_q <= 1'b0;
        end
    end

    assign due = !sent_q || (cand != last_q);

    AST_SYNC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_seen && !fire) |=> due); // R11

    AST_FIRE_RECORDS: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (sent_q && last_q == $past(fire_val))); // R11

endmodule

// File: rtl/tpkt_seq.sv
`timescale 1ns/1ps
module tpkt_seq
    import tpkt_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int MODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    output logic              ev_ready,
    input  logic [1:0]        ev_kind,
    input  logic              en_before,
    input  logic              en_after,
    input  logic              ctx_after,
    input  logic              pt_base_upd,
    input  logic              os_trace_on,
    input  logic              dest_nonroot,
    input  logic              conceal_nonroot,
    input  logic              mode_width_chg,
    input  logic              stop_region_hit,
    input  logic [MODE_W-1:0] mode_val,
    input  logic [ADDR_W-1:0] pt_base,
    input  logic [ADDR_W-1:0] cur_ip,
    input  logic [ADDR_W-1:0] next_ip,
    input  logic [ADDR_W-1:0] target_ip,
    input  logic              sync_seen,
    output logic              pk_valid,
    input  logic              pk_ready,
    output logic [2:0]        pk_type,
    output logic              pk_nonroot,
    output logic [ADDR_W-1:0] pk_payload,
    output logic              seq_done
);

    seq_st_t st_q, st_d;
    plan_t   plan_d, plan_q;
    logic    accept;
    logic    mode_due;
    logic    mode_fire;

    logic [ADDR_W-1:0] cur_q, nxt_q, tgt_q, ptb_q;
    logic [MODE_W-1:0] mode_q;
    logic              nonroot_q;

    // ---------------- sub-blocks ----------------
    tpkt_plan u_plan (
        .ev_kind   (ev_kind),
        .en_before (en_before),
        .en_after  (en_after),
        .ctx_after (ctx_after),
        .pip_ok    (pt_base_upd && os_trace_on),
        .stop_hit  (stop_region_hit),
        .width_chg (mode_width_chg),
        .mode_due  (mode_due),
        .plan      (plan_d)
    );

    tpkt_mode_track #(.MODE_W(MODE_W)) u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_seen (sync_seen),
        .fire      (mode_fire),
        .fire_val  (mode_q),
        .cand      (mode_val),
        .due       (mode_due)
    );

    // ---------------- step helpers ----------------
    function automatic seq_st_t idx_to_st(input int i);
        seq_st_t r;
        unique case (i)
            0:       r = ST_FUP_CUR;
            1:       r = ST_FUP_NXT_LEAD;
            2:       r = ST_PAGING;
            3:       r = ST_FUP_NXT;
            4:       r = ST_MODE;
            5:       r = ST_BRANCH;
            6:       r = ST_STOP;
            default: r = ST_DONE;
        endcase
        return r;
    endfunction

    function automatic int st_to_idx(input seq_st_t s);
        int r;
        unique case (s)
            ST_FUP_CUR:      r = 0;
            ST_FUP_NXT_LEAD: r = 1;
            ST_PAGING:       r = 2;
            ST_FUP_NXT:      r = 3;
            ST_MODE:         r = 4;
            ST_BRANCH:       r = 5;
            ST_STOP:         r = 6;
            default:         r = N_STEPS;
        endcase
        return r;
    endfunction

    // first planned step at or after position 'from', else the done state
    function automatic seq_st_t pick_next(input logic [N_STEPS-1:0] m, input int from);
        seq_st_t r;
        r = ST_DONE;
        for (int i = N_STEPS - 1; i >= 0; i--) begin
            if (i >= from && m[i]) r = idx_to_st(i);
        end
        return r;
    endfunction

    assign accept    = ev_valid && (st_q == ST_IDLE);
    assign mode_fire = (st_q == ST_MODE) && pk_ready;

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // ---------------- event capture ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            plan_q    <= '0;
            cur_q     <= '0;
            nxt_q     <= '0;
            tgt_q     <= '0;
            ptb_q     <= '0;
            mode_q    <= '0;
            nonroot_q <= 1'b0;
        end else if (accept) begin
            plan_q    <= plan_d;
            cur_q     <= cur_ip;
            nxt_q     <= next_ip;
            tgt_q     <= target_ip;
            ptb_q     <= pt_base;
            mode_q    <= mode_val;
            nonroot_q <= dest_nonroot && !conceal_nonroot;
        end
    end

    // ---------------- transitions ----------------
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (ev_valid) st_d = pick_next(N_STEPS'(plan_d.steps), 0);
            end
            ST_FUP_CUR, ST_FUP_NXT_LEAD, ST_PAGING, ST_FUP_NXT,
            ST_MODE, ST_BRANCH, ST_STOP: begin
                if (pk_ready) st_d = pick_next(N_STEPS'(plan_q.steps), st_to_idx(st_q) + 1);
            end
            ST_DONE: st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        ev_ready   = 1'b0;
        pk_valid   = 1'b0;
        pk_type    = PK_NONE;
        pk_nonroot = 1'b0;
        pk_payload = '0;
        seq_done   = 1'b0;
        unique case (st_q)
            ST_IDLE: ev_ready = 1'b1;
            ST_FUP_CUR: begin
                pk_valid   = 1'b1;
                pk_type    = PK_FLOW;
                pk_payload = cur_q;
            end
            ST_FUP_NXT_LEAD, ST_FUP_NXT: begin
                pk_valid   = 1'b1;
                pk_type    = PK_FLOW;
                pk_payload = nxt_q;
            end
            ST_PAGING: begin
                pk_valid   = 1'b1;
                pk_type    = PK_PAGING;
                pk_nonroot = nonroot_q;
                pk_payload = ptb_q;
            end
            ST_MODE: begin
                pk_valid   = 1'b1;
                pk_type    = PK_MODE;
                pk_payload = ADDR_W'(mode_q);
            end
            ST_BRANCH: begin
                pk_valid   = 1'b1;
                pk_type    = plan_q.br_kind;
                pk_payload = plan_q.br_with_tgt ? tgt_q : '0;
            end
            ST_STOP: begin
                pk_valid   = 1'b1;
                pk_type    = PK_STOP;
            end
            ST_DONE: seq_done = 1'b1;
            default: ;
        endcase
    end

    // ---------------- assertions ----------------
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !(pk_valid && ev_ready)); // R1

    AST_ACCEPT_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_ready) |=> !ev_ready); // R1

    AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        (pk_valid && !pk_ready) |=> (pk_valid && $stable(pk_type) && $stable(pk_payload))); // R2

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> (!seq_done && ev_ready)); // R2

    AST_NONROOT_ONLY_PAGING: assert property (@(posedge clk) disable iff (!rst_n)
        pk_nonroot |-> (pk_valid && pk_type == PK_PAGING)); // R10

    AST_STOP_IS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (pk_valid && pk_ready && pk_type == PK_STOP) |=> seq_done); // R13

endmodule

// File: tb/tpkt_seq_tb.sv
`timescale 1ns/1ps
module tpkt_seq_tb;

    localparam int AW = 64;
    localparam int MW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ev_valid = 1'b0;
    logic          ev_ready;
    logic [1:0]    ev_kind = '0;
    logic          en_before = 1'b0, en_after = 1'b0, ctx_after = 1'b0;
    logic          pt_base_upd = 1'b0, os_trace_on = 1'b0, dest_nonroot = 1'b0;
    logic          conceal_nonroot = 1'b0, mode_width_chg = 1'b0, stop_region_hit = 1'b0;
    logic [MW-1:0] mode_val = '0;
    logic [AW-1:0] pt_base = '0, cur_ip = '0, next_ip = '0, target_ip = '0;
    logic          sync_seen = 1'b0;
    logic          pk_valid;
    logic          pk_ready = 1'b0;
    logic [2:0]    pk_type;
    logic          pk_nonroot;
    logic [AW-1:0] pk_payload;
    logic          seq_done;

    always #2.5 clk = ~clk;

    tpkt_seq #(.ADDR_W(AW), .MODE_W(MW)) u_dut (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
        .ev_kind(ev_kind), .en_before(en_before), .en_after(en_after), .ctx_after(ctx_after),
        .pt_base_upd(pt_base_upd), .os_trace_on(os_trace_on), .dest_nonroot(dest_nonroot),
        .conceal_nonroot(conceal_nonroot), .mode_width_chg(mode_width_chg),
        .stop_region_hit(stop_region_hit), .mode_val(mode_val), .pt_base(pt_base),
        .cur_ip(cur_ip), .next_ip(next_ip), .target_ip(target_ip), .sync_seen(sync_seen),
        .pk_valid(pk_valid), .pk_ready(pk_ready), .pk_type(pk_type), .pk_nonroot(pk_nonroot),
        .pk_payload(pk_payload), .seq_done(seq_done)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;
    int cycles = 0;
    int rdy_ctr = 0;

    // bench-side record of the mode packet history (R11)
    bit            b_sent = 0;
    logic [MW-1:0] b_last = '0;

    logic [2:0]    e_type [8];
    logic [AW-1:0] e_pay  [8];
    logic          e_nr   [8];
    string         e_tag  [8];
    int            n_exp;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic push(input logic [2:0] t, input logic [AW-1:0] p, input logic nr, input string tag);
        e_type[n_exp] = t;
        e_pay[n_exp]  = p;
        e_nr[n_exp]   = nr;
        e_tag[n_exp]  = tag;
        n_exp++;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
            summary();
        end
    end

    task automatic run_event(input int k, input logic [2:0] bac, input logic [5:0] f,
                             input logic [MW-1:0] mv, input logic [AW-1:0] seed);
        logic pu, os, nr, cc, wc, sh, pip, nrf;
        logic [AW-1:0] c_ip, n_ip, t_ip, ptb;
        string ev_tag;
        int got;
        bit stall_pend;
        logic [2:0] s_t;
        logic [AW-1:0] s_p;
        int guard;

        {sh, wc, cc, nr, os, pu} = f;
        pip  = pu && os;
        nrf  = nr && !cc;
        c_ip = seed ^ 64'hC0DE_0000_0000_0000;
        n_ip = c_ip + 64'd4;
        t_ip = seed ^ 64'h7A26_0000_0000_1000;
        ptb  = seed ^ 64'h0000_5AB0_0000_0000;

        n_exp = 0;
        ev_tag = "R3";
        if (k == 1) begin
            unique case (bac)
                3'b001: begin
                    ev_tag = "R9";
                    if (pip) push(3'd2, ptb, nrf, "R10");
                    if (sh)  push(3'd7, '0, 1'b0, "R13");
                end
                3'b011: begin
                    ev_tag = "R5";
                    if (pip) push(3'd2, ptb, nrf, "R10");
                    if (!b_sent || mv != b_last) begin
                        push(3'd3, AW'(mv), 1'b0, "R11");
                        b_sent = 1; b_last = mv;
                    end
                    push(3'd4, t_ip, 1'b0, "R5");
                end
                3'b100: begin
                    ev_tag = "R4";
                    push(3'd1, c_ip, 1'b0, "R4");
                    push(3'd5, '0, 1'b0, "R4");
                end
                3'b101: begin
                    ev_tag = "R6";
                    push(3'd1, c_ip, 1'b0, "R6");
                    if (pip) push(3'd2, ptb, nrf, "R10");
                    push(3'd5, t_ip, 1'b0, "R6");
                    if (sh)  push(3'd7, '0, 1'b0, "R13");
                end
                3'b111: begin
                    ev_tag = "R7";
                    push(3'd1, c_ip, 1'b0, "R7");
                    if (pip) push(3'd2, ptb, nrf, "R10");
                    push(3'd1, n_ip, 1'b0, "R7");
                    if (wc) begin
                        push(3'd3, AW'(mv), 1'b0, "R12");
                        b_sent = 1; b_last = mv;
                    end
                    push(3'd6, t_ip, 1'b0, "R7");
                end
                default: ev_tag = "R3";
            endcase
        end else if (k == 0) begin
            ev_tag = "R8";
            if (bac == 3'b111) begin
                push(3'd1, n_ip, 1'b0, "R8");
                if (pip) push(3'd2, ptb, nrf, "R10");
                if (wc) begin
                    push(3'd3, AW'(mv), 1'b0, "R12");
                    b_sent = 1; b_last = mv;
                end
                push(3'd6, t_ip, 1'b0, "R8");
            end
        end

        @(negedge clk);
        ev_kind = k[1:0];
        {en_before, en_after, ctx_after} = bac;
        {stop_region_hit, mode_width_chg, conceal_nonroot, dest_nonroot, os_trace_on, pt_base_upd} = f;
        mode_val = mv;
        cur_ip = c_ip; next_ip = n_ip; target_ip = t_ip; pt_base = ptb;
        ev_valid = 1'b1;
        chk(ev_ready === 1'b1, "R1", "ready when idle", AW'(ev_ready), 64'd1);
        @(negedge clk);
        ev_valid = 1'b0;
        chk(ev_ready === 1'b0, "R1", "ready while busy", AW'(ev_ready), 64'd0);

        got = 0;
        stall_pend = 0;
        s_t = '0;
        s_p = '0;
        guard = 0;
        while (seq_done !== 1'b1 && guard < 64) begin
            pk_ready = (rdy_ctr % 3) != 2;
            rdy_ctr++;
            if (stall_pend) begin
                chk(pk_valid === 1'b1 && pk_type === s_t && pk_payload === s_p,
                    "R2", "held while stalled", pk_payload, s_p);
                stall_pend = 0;
            end
            if (pk_valid === 1'b1) begin
                if (pk_ready) begin
                    if (got < n_exp) begin
                        chk(pk_type === e_type[got], e_tag[got], "packet type", AW'(pk_type), AW'(e_type[got]));
                        chk(pk_payload === e_pay[got], e_tag[got], "payload", pk_payload, e_pay[got]);
                        chk(pk_nonroot === e_nr[got], "R10", "nonroot flag", AW'(pk_nonroot), AW'(e_nr[got]));
                    end else begin
                        chk(1'b0, ev_tag, "extra packet", AW'(pk_type), 64'd0);
                    end
                    got++;
                end else begin
                    stall_pend = 1;
                    s_t = pk_type;
                    s_p = pk_payload;
                end
            end
            @(negedge clk);
            guard++;
        end
        pk_ready = 1'b0;
        chk(seq_done === 1'b1, "R2", "done pulse seen", AW'(seq_done), 64'd1);
        chk(got == n_exp, ev_tag, "packet count", AW'(got), AW'(n_exp));
        @(negedge clk);
        chk(ev_ready === 1'b1 && seq_done === 1'b0, "R2", "idle after done", AW'({seq_done, ev_ready}), 64'd1);
    endtask

    initial begin
        int idx;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pk_valid === 1'b0, "R1", "reset pk_valid", AW'(pk_valid), 64'd0);
        chk(ev_ready === 1'b1, "R1", "reset ev_ready", AW'(ev_ready), 64'd1);
        chk(seq_done === 1'b0, "R1", "reset seq_done", AW'(seq_done), 64'd0);

        idx = 0;
        for (int k = 0; k < 3; k++) begin
            for (int b = 0; b < 8; b++) begin
                for (int f = 0; f < 64; f++) begin
                    if (idx % 53 == 52) begin
                        @(negedge clk);
                        sync_seen = 1'b1;
                        @(negedge clk);
                        sync_seen = 1'b0;
                        b_sent = 0;
                    end
                    run_event(k, 3'(b), 6'(f), MW'(idx / 7), 64'(idx) * 64'h0000_0001_0001_0010);
                    idx++;
                end
            end
        end
        // the alternate exception code must also stay silent (R3)
        run_event(3, 3'b111, 6'h3F, 3'd5, 64'h1234);
        summary();
    end

endmodule